// File: doc/BRIEF.md
# Phased Block Reset Sequencer

This block drives a reset/clear controller through a cascading sweep of the array's mirror blocks so that a binary frame is visible for only a very short time. Each block is written with new data and then reset so that the data appears. After a configurable number of later blocks has been written, the block is cleared and reset again, which ends its display. The visible region is a narrow window that travels from block 0 to the last block. The settle time that follows every reset is hidden behind the writes to the blocks further down the array.

The sequencer issues one command at a time: write block, reset block or clear block, each with a block index. It then waits for the controller's completion pulse. A per-block lockout vector from the controller marks blocks that are still settling. No command goes to a locked block, and the sequencer stalls until the lock drops. A start pulse launches a sweep from idle. If another frame is available when the final clearing reset of the last block completes, the next sweep starts at once. Otherwise the sequencer goes idle with every block cleared. A lag selector chooses how many blocks the write front runs ahead of the clearing front. It is sampled once at the start of each sweep.

Top module: `phased_reset_seq`

## Requirements
- R1: After reset, cmd_valid_o and frame_done_o stay low until start_i is pulsed.
- R2: Operation codes on cmd_op_o are write=1, reset=2, clear=3. Each block receives in order: write, reset, clear, reset.
- R3: With lag L = lead_sel_i+1, the sweep visits blocks in ascending order. For each step k it issues write k and reset k (while k < NUM_BLOCKS), then clear k-L and reset k-L (while k >= L). The step index k runs from 0 to NUM_BLOCKS-1+L.
- R4: Only one command is outstanding at a time. After cmd_valid_o, the next cmd_valid_o comes no earlier than the cycle after cmd_done_i.
- R5: cmd_valid_o is never raised for a block whose lockout_i bit is set. The pending command is held unchanged and issued once the bit clears.
- R6: frame_done_o pulses high for exactly one cycle. That cycle is the one after cmd_done_i for the clearing reset of the last block.
- R7: If frame_avail_i is high when that final completion arrives, the write of block 0 for the next sweep is issued in the same cycle that frame_done_o is high.
- R8: If frame_avail_i is low at that point, the sequencer goes idle with every block cleared and reset, and it issues no command until the next start_i.
- R9: lead_sel_i is sampled only when a sweep starts; changes during a sweep are ignored. start_i during a sweep is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch a sweep from idle |
| frame_avail_i | input | 1 | Another frame is ready at the end of a sweep |
| lead_sel_i | input | LEAD_W | Lag between write front and clear front, minus one |
| cmd_done_i | input | 1 | Controller completed the outstanding command |
| lockout_i | input | NUM_BLOCKS | Per-block settle lockout |
| cmd_valid_o | output | 1 | Command issued this cycle |
| cmd_op_o | output | 2 | Operation code (1 write, 2 reset, 3 clear) |
| cmd_blk_o | output | $clog2(NUM_BLOCKS) | Target block index |
| frame_done_o | output | 1 | Final clearing reset of the last block completed |

## Verification
The hardest situations to reach are a stall on a settling block and a frame chained back-to-back to the next. A stall needs a clear to fall due while its block's earlier reset is still settling. A chained frame needs frame_avail_i held across the final completion. The bench's controller model raises a block's lockout for a fixed settle window after every reset it completes. With the lag set to one, a clear lands inside that window, so stalls arise naturally. A run with frame_avail_i held high chains two sweeps with different lags.

// File: rtl/phased_seq_pkg.sv
package phased_seq_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_RESET = 2'd2,
    OP_CLEAR = 2'd3
  } blk_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/sweep_planner.sv
module sweep_planner
  import phased_seq_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int LEAD_W     = 2,
  localparam int MAX_LEAD  = 1 << LEAD_W,
  localparam int BLK_W     = $clog2(NUM_BLOCKS),
  localparam int STEP_W    = $clog2(NUM_BLOCKS + MAX_LEAD),
  localparam int LAG_W     = LEAD_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  input  logic              advance_i,
  input  logic [LEAD_W-1:0] lead_sel_i,
  output blk_op_e           op_o,
  output logic [BLK_W-1:0]  blk_o,
  output logic              last_o
);

  localparam logic [STEP_W-1:0] TOP_BLK = STEP_W'(NUM_BLOCKS - 1);

  // phase: 0 write front, 1 show reset, 2 clear trail, 3 end reset
  logic [STEP_W-1:0] step_q, step_n;
  logic [1:0]        ph_q, ph_n;
  logic [LAG_W-1:0]  lag_q, lag_n;
  logic              upd_en;
  logic              trail_ok;
  logic [STEP_W-1:0] step_inc;
  logic [STEP_W-1:0] lag_ext;

  assign lag_ext  = STEP_W'(lag_q);
  assign trail_ok = (step_q >= lag_ext);
  assign step_inc = step_q + STEP_W'(1);
  assign upd_en   = restart_i | advance_i;

  always_comb begin
    step_n = step_q;
    ph_n   = ph_q;
    lag_n  = lag_q;
    if (restart_i) begin
      step_n = '0;
      ph_n   = 2'd0;
      lag_n  = LAG_W'(lead_sel_i) + LAG_W'(1);
    end else if (advance_i) begin
      unique case (ph_q)
        2'd0: ph_n = 2'd1;
        2'd1: begin
          if (trail_ok) begin
            ph_n = 2'd2;
          end else begin
            step_n = step_inc;
            ph_n   = (step_inc <= TOP_BLK) ? 2'd0 : 2'd2;
          end
        end
        2'd2: ph_n = 2'd3;
        default: begin
          step_n = step_inc;
          ph_n   = (step_inc <= TOP_BLK) ? 2'd0 : 2'd2;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      ph_q   <= 2'd0;
      lag_q  <= LAG_W'(1);
    end else if (upd_en) begin
      step_q <= step_n;
      ph_q   <= ph_n;
      lag_q  <= lag_n;
    end
  end

  always_comb begin
    unique case (ph_q)
      2'd0:    op_o = OP_WRITE;
      2'd2:    op_o = OP_CLEAR;
      default: op_o = OP_RESET;
    endcase
  end

  assign blk_o  = ph_q[1] ? BLK_W'(step_q - lag_ext) : BLK_W'(step_q);
  assign last_o = (ph_q == 2'd3) && (step_q == TOP_BLK + lag_ext);

  AST_TRAIL_BEHIND_FRONT: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q[1] |-> (step_q >= lag_ext)); // R3
  AST_FRONT_IN_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_q[1] |-> (step_q <= TOP_BLK)); // R3
  AST_LAG_HELD_MID_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !restart_i |=> $stable(lag_q)); // R9

endmodule

// File: rtl/cmd_issuer.sv
module cmd_issuer
  import phased_seq_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  frame_avail_i,
  input  logic                  cmd_done_i,
  input  logic [NUM_BLOCKS-1:0] lockout_i,
  input  blk_op_e               plan_op_i,
  input  logic [BLK_W-1:0]      plan_blk_i,
  input  logic                  plan_last_i,
  output logic                  restart_o,
  output logic                  advance_o,
  output logic                  cmd_valid_o,
  output blk_op_e               cmd_op_o,
  output logic [BLK_W-1:0]      cmd_blk_o,
  output logic                  frame_done_o
);

  seq_state_e state_q, state_n;
  logic       fd_q, fd_n;
  logic       blocked;

  assign blocked = lockout_i[plan_blk_i];

  always_comb begin
    state_n   = state_q;
    restart_o = 1'b0;
    advance_o = 1'b0;
    fd_n      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          restart_o = 1'b1;
          state_n   = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (!blocked) state_n = ST_WAIT;
      end
      ST_WAIT: begin
        if (cmd_done_i) begin
          if (plan_last_i) begin
            fd_n = 1'b1;
            if (frame_avail_i) begin
              restart_o = 1'b1;
              state_n   = ST_ISSUE;
            end else begin
              state_n = ST_IDLE;
            end
          end else begin
            advance_o = 1'b1;
            state_n   = ST_ISSUE;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fd_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      fd_q    <= fd_n;
    end
  end

  assign cmd_valid_o  = (state_q == ST_ISSUE) && !blocked;
  assign cmd_op_o     = cmd_valid_o ? plan_op_i : OP_NONE;
  assign cmd_blk_o    = plan_blk_i;
  assign frame_done_o = fd_q;

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o); // R4
  AST_STALL_HOLDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ISSUE && blocked) |=> ($stable(plan_blk_i) && $stable(plan_op_i))); // R5
  AST_FRAME_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o); // R6

endmodule

// File: rtl/phased_reset_seq.sv
module phased_reset_seq
  import phased_seq_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int LEAD_W     = 2,
  localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  frame_avail_i,
  input  logic [LEAD_W-1:0]     lead_sel_i,
  input  logic                  cmd_done_i,
  input  logic [NUM_BLOCKS-1:0] lockout_i,
  output logic                  cmd_valid_o,
  output logic [1:0]            cmd_op_o,
  output logic [BLK_W-1:0]      cmd_blk_o,
  output logic                  frame_done_o
);

  blk_op_e          plan_op;
  logic [BLK_W-1:0] plan_blk;
  logic             plan_last;
  logic             restart;
  logic             advance;
  blk_op_e          issue_op;

  sweep_planner #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .LEAD_W     (LEAD_W)
  ) u_plan (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart_i  (restart),
    .advance_i  (advance),
    .lead_sel_i (lead_sel_i),
    .op_o       (plan_op),
    .blk_o      (plan_blk),
    .last_o     (plan_last)
  );

  cmd_issuer #(
    .NUM_BLOCKS (NUM_BLOCKS)
  ) u_issue (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .frame_avail_i (frame_avail_i),
    .cmd_done_i    (cmd_done_i),
    .lockout_i     (lockout_i),
    .plan_op_i     (plan_op),
    .plan_blk_i    (plan_blk),
    .plan_last_i   (plan_last),
    .restart_o     (restart),
    .advance_o     (advance),
    .cmd_valid_o   (cmd_valid_o),
    .cmd_op_o      (issue_op),
    .cmd_blk_o     (cmd_blk_o),
    .frame_done_o  (frame_done_o)
  );

  assign cmd_op_o = issue_op;

  AST_DONE_AFTER_LAST_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> ($past(plan_op) == OP_RESET &&
                      $past(plan_blk) == BLK_W'(NUM_BLOCKS - 1))); // R6
  AST_NO_LOCKED_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> !lockout_i[cmd_blk_o]); // R5

endmodule

// File: tb/test_phased_reset_seq.sv
`timescale 1ns/100ps
module test_phased_reset_seq;
  localparam int N      = 16;
  localparam int LW     = 2;
  localparam int BW     = $clog2(N);
  localparam int SETTLE = 40;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic          frame_avail;
  logic [LW-1:0] lead_sel;
  logic          cmd_done;
  logic [N-1:0]  lockout;
  logic          cmd_valid;
  logic [1:0]    cmd_op;
  logic [BW-1:0] cmd_blk;
  logic          frame_done;

  phased_reset_seq #(.NUM_BLOCKS(N), .LEAD_W(LW)) i_phased_reset_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .frame_avail_i(frame_avail),
    .lead_sel_i(lead_sel), .cmd_done_i(cmd_done), .lockout_i(lockout),
    .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op), .cmd_blk_o(cmd_blk),
    .frame_done_o(frame_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];
  int fd_count = 0;
  int stall_seen = 0;
  logic fd_pend, fd_exp;
  int settle_cnt[N];
  logic mem[N];
  logic mirror[N];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // driver: expected command stream of one sweep with lag L
  task automatic push_frame(input int lag);
    for (int k = 0; k <= N - 1 + lag; k++) begin
      if (k < N) begin
        exp_q.push_back(1 * 256 + k);
        exp_q.push_back(2 * 256 + k);
      end
      if (k >= lag) begin
        exp_q.push_back(3 * 256 + (k - lag));
        exp_q.push_back(2 * 256 + (k - lag));
      end
    end
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_frames(input int target);
    while (fd_count < target) @(negedge clk);
  endtask

  task automatic check_all_cleared(input string tag);
    int bad = 0;
    for (int b = 0; b < N; b++) if (mem[b] || mirror[b]) bad++;
    check(bad == 0, tag, "blocks left showing or loaded", bad, 0);
    check(exp_q.size() == 0, tag, "commands still expected", exp_q.size(), 0);
  endtask

  // controller model: completion latency 1..3, settle lockout after resets
  initial begin : ctrl
    int pend;
    int ncmd;
    int cur_op;
    int cur_blk;
    pend = 0; ncmd = 0; cur_op = 0; cur_blk = 0;
    cmd_done = 1'b0; lockout = '0; fd_pend = 1'b0; fd_exp = 1'b0;
    for (int b = 0; b < N; b++) begin
      settle_cnt[b] = 0; mem[b] = 1'b0; mirror[b] = 1'b0;
    end
    forever begin
      @(negedge clk);
      if (rst_n && cmd_valid && pend == 0) begin
        pend = 1 + (ncmd % 3);
        ncmd++;
        cur_op = int'(cmd_op);
        cur_blk = int'(cmd_blk);
      end
      @(posedge clk); #1;
      fd_exp = fd_pend;
      fd_pend = 1'b0;
      cmd_done = 1'b0;
      for (int b = 0; b < N; b++) if (settle_cnt[b] > 0) settle_cnt[b]--;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          cmd_done = 1'b1;
          case (cur_op)
            1: mem[cur_blk] = 1'b1;
            3: mem[cur_blk] = 1'b0;
            2: begin
              if (cur_blk == N - 1 && !mem[cur_blk] && mirror[cur_blk]) fd_pend = 1'b1;
              mirror[cur_blk] = mem[cur_blk];
              settle_cnt[cur_blk] = SETTLE;
            end
            default: ;
          endcase
        end
      end
      for (int b = 0; b < N; b++) lockout[b] = (settle_cnt[b] != 0);
    end
  end

  // monitor / scoreboard
  initial begin : mon
    logic done_prev;
    done_prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (frame_done || fd_exp)
          check(frame_done == fd_exp, "R6", "frame_done pulse", frame_done, fd_exp);
        if (frame_done) begin
          fd_count++;
          if (frame_avail)
            check(cmd_valid && cmd_op == 2'd1 && cmd_blk == '0, "R7",
                  "immediate next sweep write0 (valid,op*256+blk)",
                  int'(cmd_valid) * 1024 + int'(cmd_op) * 256 + int'(cmd_blk), 1024 + 256);
        end
        if (done_prev && !cmd_valid && exp_q.size() > 0 && !frame_done) stall_seen++;
        if (cmd_valid) begin
          check(!lockout[cmd_blk], "R5", "command to locked block", int'(cmd_blk), -1);
          if (exp_q.size() == 0) begin
            check(1'b0, "R8", "unexpected command op*256+blk",
                  int'(cmd_op) * 256 + int'(cmd_blk), -1);
          end else begin
            int e;
            e = exp_q.pop_front();
            check(int'(cmd_op) * 256 + int'(cmd_blk) == e, "R2 R3",
                  "command op*256+blk", int'(cmd_op) * 256 + int'(cmd_blk), e);
          end
        end
        done_prev = cmd_done;
      end
    end
  end

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", fd_count, 4);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; start = 1'b0; frame_avail = 1'b0; lead_sel = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: quiet after reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!cmd_valid && !frame_done, "R1", "output after reset",
            int'(cmd_valid) * 2 + int'(frame_done), 0);
    end

    // Lag 2, single frame; lead change and start mid-sweep ignored (R9)
    lead_sel = 2'd1;
    push_frame(2);
    pulse_start();
    repeat (30) @(posedge clk);
    #1 lead_sel = 2'd3;
    pulse_start();
    wait_frames(1);
    repeat (30) @(negedge clk);
    check_all_cleared("R8");
    check(!cmd_valid, "R8", "idle command", int'(cmd_valid), 0);

    // Lag 1 then lag 3, chained frames (R7), stalls on settling blocks (R5)
    @(posedge clk); #1 lead_sel = 2'd0; frame_avail = 1'b1;
    push_frame(1);
    push_frame(3);
    pulse_start();
    repeat (20) @(posedge clk);
    #1 lead_sel = 2'd2;
    wait_frames(2);
    @(posedge clk); #1 frame_avail = 1'b0;
    wait_frames(3);
    repeat (30) @(negedge clk);
    check_all_cleared("R8");
    check(stall_seen > 0, "R5", "stalls observed on locked blocks", stall_seen, 1);

    // Lag 4, single frame
    @(posedge clk); #1 lead_sel = 2'd3;
    push_frame(4);
    pulse_start();
    wait_frames(4);
    repeat (30) @(negedge clk);
    check_all_cleared("R3");
    check(fd_count == 4, "R6", "frame_done count", fd_count, 4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule